// File: doc/BRIEF.md
# Metering Status and Interrupt Aggregator

This block gathers the condition and event flags of a three-phase energy measurement engine into one 20-bit status word that the host can only read. It also drives an active-low interrupt pin whenever any status bit that the host has enabled in a mask register is set. Some bits follow their source signals directly: sag, creep and fundamental polarity. Others are latched and cleared by a read of the status word: boot request, data ready and command ignored. The one-second bit toggles on each tick.

A group of bits is evaluated once per accumulation interval, on the interval strobe. Over-limit detections, comparator and pin edges, missed host energy reads and missed pulse-generator updates are collected during the interval in shadow state. On the strobe they are copied into the status word in one step, and the shadow state is cleared. The miss watchdogs arm on the first strobe after reset, so the partial interval that follows reset is never reported as a miss.

Host access uses plain strobes: one write strobe and one read strobe, which share an address and a write data bus. Read data comes back combinationally from the address. The block has no streaming data path, so no valid/ready handshake and no back-pressure apply.

Top module: `meter_status_irq`

## Requirements
- R1: After reset the status word reads 0x00001 (only bit 0, boot request, set, with all live inputs low), the mask reads 0, and `irq_n_o` is high.
- R2: Bits 1..3 follow `sag_i[0..2]`, bit 4 follows `fund_pol_i`, and bit 12+p equals `creep_energy_i[p] | creep_current_i[p]`, combinationally and without latching.
- R3: `irq_n_o` is low in the same cycle that the status word ANDed with the mask is nonzero, and high otherwise.
- R4: A write to address 1 loads the 20-bit mask. `host_rdata_o` returns the status word at address 0, the mask at address 1, and 0 at any other address.
- R5: A write to a read-only address is refused: it leaves the mask unchanged and sets bit 15 in the following cycle. By default every address except 1 is read-only. A pulse on `cmd_reject_i` also sets bit 15.
- R6: A read strobe at address 0 clears bits 0, 11 and 15 in the following cycle. When a set event for one of these bits occurs in the same cycle, the set wins. Bit 0 is never set again until the next reset.
- R7: Each `sec_tick_i` pulse inverts bit 7 in the following cycle.
- R8: On the interval strobe, bit 5 (voltage over-limit) and bit 6 (current over-limit) take the OR of their detections over the interval that ends with that strobe cycle. The two bits do not change between strobes.
- R9: On the interval strobe, bit 8 reports whether `cmp_i` changed state during the interval, and bit 9 reports whether any pin with its `pin_en_i` bit set changed state. Disabled pins are ignored.
- R10: The interval strobe sets bit 11 (data ready) in the following cycle.
- R11: On an armed strobe, bit 10 is set if none of the three `energy_rd_i` strobes pulsed since the previous strobe, the strobe cycle included. On the first strobe after reset, bit 10 stays 0.
- R12: On an armed strobe, bit 16+g is set if `gen_ext_i[g]` is 1 and `pulse_upd_i[g]` did not pulse during the interval, the strobe cycle included. Otherwise the bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_strobe_i | input | 1 | One-cycle pulse that closes an accumulation interval |
| sag_i | input | 3 | Per-phase sag indication, live |
| creep_energy_i | input | 3 | Per-phase energy below creep threshold |
| creep_current_i | input | 3 | Per-phase current below start threshold |
| fund_pol_i | input | 1 | Fundamental waveform polarity |
| v_over_i | input | 1 | Voltage limit crossing detected |
| i_over_i | input | 1 | Current limit crossing detected |
| cmp_i | input | 1 | Comparator level (already synchronous) |
| pins_i | input | N_PIN | Monitored digital pin levels |
| pin_en_i | input | N_PIN | Per-pin edge enable |
| sec_tick_i | input | 1 | One-second tick pulse |
| energy_rd_i | input | 3 | Host read strobes of the per-phase energy registers |
| gen_ext_i | input | 4 | Pulse generator configured for host input |
| pulse_upd_i | input | 4 | Host update strobes per pulse generator |
| cmd_reject_i | input | 1 | Command rejected elsewhere, one-cycle pulse |
| host_wr_i | input | 1 | Host write strobe |
| host_rd_i | input | 1 | Host read strobe |
| host_addr_i | input | ADDR_W | Host address |
| host_wdata_i | input | 20 | Host write data |
| host_rdata_o | output | 20 | Host read data, combinational from address |
| status_o | output | 20 | Status word |
| irq_n_o | output | 1 | Interrupt, active low |

## Verification
A shadow accumulator that fails to clear, or that misses an event, shows up only at the next interval strobe: an over-limit, edge or miss bit holds a wrong value for a full interval. The bench therefore checks the copied bits right after each strobe, and checks them for stability before it. A wrong arming state or a wrong watchdog polarity shows up on the first or second strobe after reset as a false or missing overflow or pulse error. A fault in the mask register or the read-only decode shows up one cycle after the write, both on the mask read-back and on the interrupt pin.

// File: rtl/msi_pkg.sv
package msi_pkg;
  localparam int STATUS_W = 20;
  localparam int N_PHASE  = 3;
  localparam int N_PULSE  = 4;
  localparam int N_WIN    = 4;   // over-V, over-I, comparator edge, pin edge

  localparam int B_BOOT   = 0;
  localparam int B_SAG0   = 1;
  localparam int B_FUND   = 4;
  localparam int B_MAXV   = 5;
  localparam int B_MAXI   = 6;
  localparam int B_SEC    = 7;
  localparam int B_CMPE   = 8;
  localparam int B_PINE   = 9;
  localparam int B_XOVF   = 10;
  localparam int B_RDY    = 11;
  localparam int B_CRP0   = 12;
  localparam int B_CMDIGN = 15;
  localparam int B_PERR0  = 16;

  typedef logic [STATUS_W-1:0] status_t;
endpackage

// File: rtl/msi_window_or.sv
module msi_window_or (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  input  logic evt_i,
  output logic flag_o
);
  logic seen_q;
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      flag_q <= 1'b0;
    end else if (strobe_i) begin
      flag_q <= seen_q | evt_i;
      seen_q <= 1'b0;
    end else if (evt_i) begin
      seen_q <= 1'b1;
    end
  end

  assign flag_o = flag_q;

  AST_WIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_i |=> $stable(flag_o)); // R8
  AST_WIN_CATCH: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_i && evt_i |=> flag_o); // R9
endmodule

// File: rtl/msi_miss_watch.sv
module msi_miss_watch (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  input  logic armed_i,
  input  logic watch_en_i,
  input  logic evt_i,
  output logic miss_o
);
  logic seen_q;
  logic miss_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      miss_q <= 1'b0;
    end else if (strobe_i) begin
      miss_q <= armed_i & watch_en_i & ~(seen_q | evt_i);
      seen_q <= 1'b0;
    end else if (evt_i) begin
      seen_q <= 1'b1;
    end
  end

  assign miss_o = miss_q;

  AST_MISS_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_i && evt_i |=> !miss_o); // R11
  AST_MISS_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_i && (!armed_i || !watch_en_i) |=> !miss_o); // R12
  AST_MISS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_i |=> $stable(miss_o)); // R12
endmodule

// File: rtl/msi_host_port.sv
module msi_host_port
  import msi_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int STATUS_ADDR = 0,
  parameter int MASK_ADDR = 1,
  parameter logic [(2**ADDR_W)-1:0] RO_MAP = 16'hFFFD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  status_t           wdata_i,
  input  status_t           status_i,
  input  logic              acc_strobe_i,
  input  logic              cmd_reject_i,
  output status_t           mask_o,
  output status_t           rdata_o,
  output logic              boot_o,
  output logic              ready_o,
  output logic              cmd_ign_o
);
  status_t mask_q;
  logic    boot_q, ready_q, cmd_q;
  logic    is_ro, wr_refused, wr_mask, rd_status;

  assign is_ro      = RO_MAP[addr_i];
  assign wr_refused = wr_i & is_ro;
  assign wr_mask    = wr_i & ~is_ro & (addr_i == ADDR_W'(MASK_ADDR));
  assign rd_status  = rd_i & (addr_i == ADDR_W'(STATUS_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      boot_q  <= 1'b1;
      ready_q <= 1'b0;
      cmd_q   <= 1'b0;
    end else begin
      if (wr_mask) mask_q <= wdata_i;
      if (rd_status) boot_q <= 1'b0;
      if (acc_strobe_i) ready_q <= 1'b1;
      else if (rd_status) ready_q <= 1'b0;
      if (wr_refused || cmd_reject_i) cmd_q <= 1'b1;
      else if (rd_status) cmd_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(STATUS_ADDR)) rdata_o = status_i;
    else if (addr_i == ADDR_W'(MASK_ADDR)) rdata_o = mask_q;
  end

  assign mask_o    = mask_q;
  assign boot_o    = boot_q;
  assign ready_o   = ready_q;
  assign cmd_ign_o = cmd_q;

  AST_RO_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i && is_ro |=> $stable(mask_o) && cmd_ign_o); // R5
  AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_status && !acc_strobe_i |=> !ready_o); // R6
  AST_BOOT_NOSET: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_o |=> !boot_o); // R6
  AST_STROBE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    acc_strobe_i |=> ready_o); // R10
endmodule

// File: rtl/meter_status_irq.sv
module meter_status_irq
  import msi_pkg::*;
#(
  parameter int N_PIN = 8,
  parameter int ADDR_W = 4,
  parameter int STATUS_ADDR = 0,
  parameter int MASK_ADDR = 1,
  parameter logic [(2**ADDR_W)-1:0] RO_MAP = 16'hFFFD
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_strobe_i,
  input  logic [2:0]          sag_i,
  input  logic [2:0]          creep_energy_i,
  input  logic [2:0]          creep_current_i,
  input  logic                fund_pol_i,
  input  logic                v_over_i,
  input  logic                i_over_i,
  input  logic                cmp_i,
  input  logic [N_PIN-1:0]    pins_i,
  input  logic [N_PIN-1:0]    pin_en_i,
  input  logic                sec_tick_i,
  input  logic [2:0]          energy_rd_i,
  input  logic [3:0]          gen_ext_i,
  input  logic [3:0]          pulse_upd_i,
  input  logic                cmd_reject_i,
  input  logic                host_wr_i,
  input  logic                host_rd_i,
  input  logic [ADDR_W-1:0]   host_addr_i,
  input  logic [19:0]         host_wdata_i,
  output logic [19:0]         host_rdata_o,
  output logic [19:0]         status_o,
  output logic                irq_n_o
);
  localparam int N_MISS = N_PULSE + 1;

  logic             cmp_q, sec_q, armed_q;
  logic [N_PIN-1:0] pins_q;
  logic [N_WIN-1:0] win_evt, win_flag;
  logic [N_MISS-1:0] miss_evt, miss_en, miss_flag;
  status_t          mask, status;
  logic             boot, ready, cmd_ign;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q   <= 1'b0;
      pins_q  <= '0;
      sec_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      cmp_q  <= cmp_i;
      pins_q <= pins_i;
      if (sec_tick_i) sec_q <= ~sec_q;
      if (acc_strobe_i) armed_q <= 1'b1;
    end
  end

  assign win_evt = {|((pins_i ^ pins_q) & pin_en_i), cmp_i ^ cmp_q, i_over_i, v_over_i};

  for (genvar w = 0; w < N_WIN; w++) begin : g_win
    msi_window_or u_win (
      .clk(clk), .rst_n(rst_n), .strobe_i(acc_strobe_i),
      .evt_i(win_evt[w]), .flag_o(win_flag[w])
    );
  end

  assign miss_evt = {|energy_rd_i, pulse_upd_i};
  assign miss_en  = {1'b1, gen_ext_i};

  for (genvar m = 0; m < N_MISS; m++) begin : g_miss
    msi_miss_watch u_miss (
      .clk(clk), .rst_n(rst_n), .strobe_i(acc_strobe_i), .armed_i(armed_q),
      .watch_en_i(miss_en[m]), .evt_i(miss_evt[m]), .miss_o(miss_flag[m])
    );
  end

  msi_host_port #(
    .ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR), .MASK_ADDR(MASK_ADDR), .RO_MAP(RO_MAP)
  ) u_host (
    .clk(clk), .rst_n(rst_n), .wr_i(host_wr_i), .rd_i(host_rd_i),
    .addr_i(host_addr_i), .wdata_i(host_wdata_i), .status_i(status),
    .acc_strobe_i(acc_strobe_i), .cmd_reject_i(cmd_reject_i),
    .mask_o(mask), .rdata_o(host_rdata_o), .boot_o(boot),
    .ready_o(ready), .cmd_ign_o(cmd_ign)
  );

  always_comb begin
    status = '0;
    status[B_BOOT] = boot;
    for (int p = 0; p < N_PHASE; p++) begin
      status[B_SAG0 + p] = sag_i[p];
      status[B_CRP0 + p] = creep_energy_i[p] | creep_current_i[p];
    end
    status[B_FUND]   = fund_pol_i;
    status[B_MAXV]   = win_flag[0];
    status[B_MAXI]   = win_flag[1];
    status[B_SEC]    = sec_q;
    status[B_CMPE]   = win_flag[2];
    status[B_PINE]   = win_flag[3];
    status[B_XOVF]   = miss_flag[N_PULSE];
    status[B_RDY]    = ready;
    status[B_CMDIGN] = cmd_ign;
    for (int g = 0; g < N_PULSE; g++) status[B_PERR0 + g] = miss_flag[g];
  end

  assign status_o = status;
  assign irq_n_o  = ~|(status & mask);

  AST_SEC_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick_i |=> status_o[B_SEC] != $past(status_o[B_SEC])); // R7
  AST_SEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick_i |=> $stable(status_o[B_SEC])); // R7
  AST_IRQ_IDLE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> irq_n_o); // R3
endmodule

// File: tb/test_meter_status_irq.sv
`timescale 1ns/1ps
module test_meter_status_irq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_strobe = 0, fund = 0, v_over = 0, i_over = 0, cmp = 0, sec = 0, creject = 0;
  logic hwr = 0, hrd = 0;
  logic [2:0] sag = 0, ce = 0, cc = 0, erd = 0;
  logic [7:0] pins = 0, pin_en = 0;
  logic [3:0] gext = 0, pupd = 0;
  logic [3:0] haddr = 0;
  logic [19:0] hwdata = 0, hrdata, status;
  logic irq_n;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  meter_status_irq i_meter_status_irq (
    .clk(clk), .rst_n(rst_n), .acc_strobe_i(acc_strobe), .sag_i(sag),
    .creep_energy_i(ce), .creep_current_i(cc), .fund_pol_i(fund),
    .v_over_i(v_over), .i_over_i(i_over), .cmp_i(cmp), .pins_i(pins),
    .pin_en_i(pin_en), .sec_tick_i(sec), .energy_rd_i(erd), .gen_ext_i(gext),
    .pulse_upd_i(pupd), .cmd_reject_i(creject), .host_wr_i(hwr), .host_rd_i(hrd),
    .host_addr_i(haddr), .host_wdata_i(hwdata), .host_rdata_o(hrdata),
    .status_o(status), .irq_n_o(irq_n)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic host_write(logic [3:0] a, logic [19:0] d);
    haddr = a; hwdata = d; hwr = 1; step(); hwr = 0;
  endtask

  task automatic read_status();
    haddr = 0; hrd = 1; step(); hrd = 0;
  endtask

  task automatic strobe();
    acc_strobe = 1; step(); acc_strobe = 0;
  endtask

  task automatic t_reset();
    haddr = 0; #1;
    chk("R1 status", status, 20'h00001);
    chk("R1 irq_n", irq_n, 1);
    haddr = 1; #1;
    chk("R1 mask", hrdata, 0);
  endtask

  task automatic t_live();
    sag = 3'b101; fund = 1; ce = 3'b001; cc = 3'b100; #1;
    chk("R2 live bits", status, 20'h0501B);
    sag = 0; fund = 0; ce = 0; cc = 0; #1;
    chk("R2 live cleared", status, 20'h00001);
  endtask

  task automatic t_mask_irq();
    host_write(1, 20'h00001);
    haddr = 1; #1;
    chk("R4 mask readback", hrdata, 20'h00001);
    chk("R3 irq on boot", irq_n, 0);
    host_write(1, 20'h00004);
    chk("R3 boot masked", irq_n, 1);
    sag = 3'b010; #1;
    chk("R3 irq on sag B", irq_n, 0);
    sag = 0; #1;
    chk("R3 irq release", irq_n, 1);
    haddr = 2; #1;
    chk("R4 other addr", hrdata, 0);
    haddr = 0; #1;
    chk("R4 status addr", hrdata, status);
  endtask

  task automatic t_ro_write();
    host_write(0, 20'hFFFFF);
    haddr = 1; #1;
    chk("R5 mask kept", hrdata, 20'h00004);
    chk("R5 cmd ignored", status[15], 1);
    read_status();
    chk("R6 cmd cleared", status[15], 0);
    chk("R6 boot cleared", status[0], 0);
    host_write(5, 20'h00000);
    haddr = 1; #1;
    chk("R5 addr5 refused", hrdata, 20'h00004);
    chk("R5 addr5 flag", status[15], 1);
    read_status();
    creject = 1; step(); creject = 0;
    chk("R5 reject pulse", status[15], 1);
    creject = 1; haddr = 0; hrd = 1; step(); creject = 0; hrd = 0;
    chk("R6 set wins", status[15], 1);
    read_status();
    chk("R6 clear again", status[15], 0);
    chk("R6 boot stays 0", status[0], 0);
  endtask

  task automatic t_sec();
    chk("R7 sec init", status[7], 0);
    sec = 1; step(); sec = 0;
    chk("R7 toggle up", status[7], 1);
    step();
    chk("R7 hold", status[7], 1);
    sec = 1; step(); sec = 0;
    chk("R7 toggle down", status[7], 0);
  endtask

  task automatic t_first_strobe();
    gext = 4'hF;
    step();
    strobe();
    chk("R10 ready set", status[11], 1);
    chk("R11 unarmed xovf", status[10], 0);
    chk("R12 unarmed perr", status[19:16], 0);
    read_status();
    chk("R6 ready cleared", status[11], 0);
  endtask

  task automatic t_interval_a();
    gext = 4'b0011; pin_en = 8'h0F;
    v_over = 1; step(); v_over = 0;
    cmp = 1; pins[7] = 1; pupd[0] = 1; step(); pupd = 0;
    step();
    chk("R8 hold before strobe", status[5], 0);
    strobe();
    chk("R8 maxv", status[5], 1);
    chk("R8 maxi", status[6], 0);
    chk("R9 cmp edge", status[8], 1);
    chk("R9 disabled pin", status[9], 0);
    chk("R11 missed read", status[10], 1);
    chk("R12 perr a", status[19:16], 4'b0010);
  endtask

  task automatic t_interval_b();
    erd = 3'b010; step(); erd = 0;
    pins[2] = 1; pupd[1] = 1; step(); pupd = 0;
    i_over = 1; strobe(); i_over = 0;
    chk("R8 maxv cleared", status[5], 0);
    chk("R8 maxi in strobe cycle", status[6], 1);
    chk("R9 cmp steady", status[8], 0);
    chk("R9 enabled pin", status[9], 1);
    chk("R11 read seen", status[10], 0);
    chk("R12 perr b", status[19:16], 4'b0001);
  endtask

  task automatic t_strobe_cycle_events();
    read_status();
    erd = 3'b100; pupd = 4'b0011; haddr = 0; hrd = 1;
    strobe();
    erd = 0; pupd = 0; hrd = 0;
    chk("R11 read in strobe cycle", status[10], 0);
    chk("R12 update in strobe cycle", status[19:16], 0);
    chk("R9 no edges", status[9:8], 0);
    chk("R6 strobe beats read", status[11], 1);
    host_write(1, 20'h00800);
    chk("R3 irq on ready", irq_n, 0);
    read_status();
    chk("R3 irq after read", irq_n, 1);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    t_reset();
    t_live();
    t_mask_irq();
    t_ro_write();
    t_sec();
    t_first_strobe();
    t_interval_a();
    t_interval_b();
    t_strobe_cycle_events();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule